// File: doc/BRIEF.md
# AUX Channel Transaction Controller

This block runs one DisplayPort AUX request/reply exchange at a time for a host that reaches it through a small word-addressed register port. Software writes the target address, then a control word holding the command code, the payload length minus one and an address-only flag. For writes it also fills up to four 32-bit transmit words. It then sets the start bit. The controller presents the whole request in parallel to a link-side port. It holds that request until the link returns a parallel reply or an internal cycle counter runs out.

When the exchange completes, the reply type, received byte count, error flags and payload are captured into status and receive registers. The start bit drops and a done interrupt is raised in the same cycle. The block also synchronises the hot-plug-detect level, reports it in the status word, and turns its edges into plug and unplug interrupts. A sink IRQ pulse feeds a fourth interrupt source. Interrupt status is write-one-to-clear and gated by an enable register before reaching `irq_o`.

Register word indices: 0 target address, 1 control, 2 status, 3 interrupt status, 4 interrupt enable, 8 to 11 transmit words 0 to 3, 12 to 15 receive words 0 to 3. Control fields: bits 3:0 length minus one, bit 4 address-only, bits 11:8 command, bit 16 start/busy. Command codes: 0 native write, 1 native read, 4 I2C write, 5 I2C read, 6 I2C write-status-update, and 12, 13, 14 for the same three I2C commands with the middle-of-transaction flag set. Payload byte k sits at bits 8k+7:8k of the link data buses, so receive word i byte j is reply byte 4i+j.

Top module: `aux_xact_ctrl`

## Requirements
- R1: After reset every register reads zero, `req_valid_o` is 0 and `irq_o` is 0.
- R2: A control write with bit 16 set and a legal command, while idle, raises `req_valid_o` after that edge. The request carries the stored address, the command, length = field+1 (0 when address-only), the address-only flag and the transmit words. Control bit 16 reads 1 while the request is in flight.
- R3: Payload packing is little-endian. Reply byte k lands in receive word k/4 at bits 8*(k%4)+7:8*(k%4), and transmit word i drives link data bits 32i+31:32i.
- R4: An address-only start is accepted only for the I2C commands (command bit 2 set). An address-only start with a native command launches nothing, and control bit 16 stays 0.
- R5: A start with a command code outside the eight legal codes launches nothing.
- R6: When `rsp_valid_i` is high during a transaction, status bits 19:16 take the reply type and bits 4:0 take the byte count, even when the count differs from the requested length. Link errors (rx, sink-status, missing-stop) set status bits 9, 10 and 11. The receive words are loaded. On that edge the start bit clears and interrupt status bit 0 sets.
- R7: With no reply, the transaction ends after TIMEOUT_CYC in-flight cycles. Status bit 8 sets, the byte count becomes 0, the start bit clears and interrupt bit 0 sets.
- R8: Status error bits 11:8 are sticky and clear only by writing 1 to them. Writing 0xF00 clears all four, and a partial mask clears only the bits it names.
- R9: While a transaction is in flight, writes to the address, control and transmit registers are ignored.
- R10: Interrupt status bits (0 done, 1 sink IRQ, 2 plug, 3 unplug) are write-one-to-clear. A new event on the same edge wins over the clear. `irq_o` is high exactly when some pending bit is also enabled in the enable register.
- R11: Status bit 28 shows `hpd_i` through a two-stage synchroniser. A rising synchronised level sets interrupt bit 2 and a falling one sets bit 3, one edge later.
- R12: A one-cycle `sink_irq_i` pulse sets interrupt status bit 1.
- R13: `rsp_valid_i` while idle changes no status or receive register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | REG_AW | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on index) |
| req_valid_o | output | 1 | Request in flight |
| req_cmd_o | output | 4 | Command code |
| req_addr_o | output | ADDR_W | Target address |
| req_len_o | output | clog2(4*NWORDS+1) | Payload byte count |
| req_addr_only_o | output | 1 | Address-only request |
| req_data_o | output | 32*NWORDS | Transmit payload |
| rsp_valid_i | input | 1 | Reply present for one cycle |
| rsp_type_i | input | 4 | Reply type code |
| rsp_count_i | input | clog2(4*NWORDS+1) | Reply byte count |
| rsp_err_i | input | 3 | Link errors: 0 rx, 1 sink-status, 2 missing-stop |
| rsp_data_i | input | 32*NWORDS | Reply payload |
| hpd_i | input | 1 | Hot-plug-detect level (asynchronous) |
| sink_irq_i | input | 1 | Sink IRQ event pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that the link port raises `rsp_valid_i` for a single cycle, and that `sink_irq_i` is synchronous to `clk_i`. Within those assumptions they hold for any register traffic, including attempts to start a transaction while one is in flight. The stimulus drives every input on the falling edge. Replies are one-cycle pulses issued only after a request has been observed. The hot-plug input is held for many cycles between changes, so each level change produces exactly one synchronised edge.

// File: rtl/aux_xact_pkg.sv
package aux_xact_pkg;
  localparam int OFF_ADDR  = 0;
  localparam int OFF_CTRL  = 1;
  localparam int OFF_STAT  = 2;
  localparam int OFF_INTS  = 3;
  localparam int OFF_INTEN = 4;
  localparam int OFF_TX    = 8;
  localparam int OFF_RX    = 12;

  localparam int CTRL_AONLY = 4;
  localparam int CTRL_CMD_LO = 8;
  localparam int CTRL_START = 16;
  localparam int STAT_ERR_LO = 8;
  localparam int STAT_TYPE_LO = 16;
  localparam int STAT_HPD = 28;

  typedef enum logic [3:0] {
    CMD_NAT_WR   = 4'h0,
    CMD_NAT_RD   = 4'h1,
    CMD_I2C_WR   = 4'h4,
    CMD_I2C_RD   = 4'h5,
    CMD_I2C_WSU  = 4'h6,
    CMD_I2CM_WR  = 4'hC,
    CMD_I2CM_RD  = 4'hD,
    CMD_I2CM_WSU = 4'hE
  } aux_cmd_e;

  function automatic logic cmd_legal(input logic [3:0] c);
    case (c)
      CMD_NAT_WR, CMD_NAT_RD, CMD_I2C_WR, CMD_I2C_RD, CMD_I2C_WSU,
      CMD_I2CM_WR, CMD_I2CM_RD, CMD_I2CM_WSU: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic cmd_is_i2c(input logic [3:0] c);
    return c[2];
  endfunction
endpackage

// File: rtl/aux_xact_seq.sv
module aux_xact_seq #(
  parameter int TIMEOUT_CYC = 2048
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic launch_i,
  input  logic rsp_valid_i,
  output logic busy_o,
  output logic finish_o,
  output logic expired_o
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  assign busy_o    = busy_q;
  assign expired_o = busy_q && !rsp_valid_i && (cnt_q == LAST);
  assign finish_o  = busy_q && (rsp_valid_i || (cnt_q == LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (launch_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end else if (finish_o) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_cnt_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q < CW'(TIMEOUT_CYC)));
  assert_launch_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |-> !busy_q);
endmodule

// File: rtl/aux_hpd_mon.sv
module aux_hpd_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hpd_i,
  output logic level_o,
  output logic plug_o,
  output logic unplug_o
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= hpd_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign level_o  = s2_q;
  assign plug_o   = s2_q && !prev_q;
  assign unplug_o = !s2_q && prev_q;

  assert_edge_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({plug_o, unplug_o}));
  assert_plug_level_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    plug_o |=> level_o);
endmodule

// File: rtl/aux_irq_ctrl.sv
module aux_irq_ctrl #(
  parameter int NSRC = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] set_i,
  input  logic            clr_we_i,
  input  logic            en_we_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] stat_o,
  output logic [NSRC-1:0] en_o,
  output logic            irq_o
);
  logic [NSRC-1:0] stat_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= (stat_q & ~(clr_we_i ? wdata_i : '0)) | set_i;
      if (en_we_i) en_q <= wdata_i;
    end
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign irq_o  = |(stat_q & en_q);

  for (genvar k = 0; k < NSRC; k++) begin : g_chk
    assert_set_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> stat_q[k]);
  end
endmodule

// File: rtl/aux_xact_ctrl.sv
module aux_xact_ctrl #(
  parameter int ADDR_W      = 20,
  parameter int NWORDS      = 4,
  parameter int TIMEOUT_CYC = 2048,
  parameter int REG_AW      = 4
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             reg_we_i,
  input  logic [REG_AW-1:0]                reg_addr_i,
  input  logic [31:0]                      reg_wdata_i,
  output logic [31:0]                      reg_rdata_o,
  output logic                             req_valid_o,
  output logic [3:0]                       req_cmd_o,
  output logic [ADDR_W-1:0]                req_addr_o,
  output logic [$clog2(4*NWORDS+1)-1:0]    req_len_o,
  output logic                             req_addr_only_o,
  output logic [32*NWORDS-1:0]             req_data_o,
  input  logic                             rsp_valid_i,
  input  logic [3:0]                       rsp_type_i,
  input  logic [$clog2(4*NWORDS+1)-1:0]    rsp_count_i,
  input  logic [2:0]                       rsp_err_i,
  input  logic [32*NWORDS-1:0]             rsp_data_i,
  input  logic                             hpd_i,
  input  logic                             sink_irq_i,
  output logic                             irq_o
);
  import aux_xact_pkg::*;

  localparam int CNT_W = $clog2(4*NWORDS+1);
  localparam int LEN_W = $clog2(4*NWORDS);
  localparam int NIRQ  = 4;

  logic [ADDR_W-1:0]           addr_q;
  logic [LEN_W-1:0]            len_m1_q;
  logic                        aonly_q;
  logic [3:0]                  cmd_q;
  logic [NWORDS-1:0][31:0]     tx_q, rx_q;
  logic [3:0]                  type_q;
  logic [CNT_W-1:0]            count_q;
  logic [3:0]                  err_q;

  logic busy, finish, expired, launch;
  logic hpd_lvl, plug, unplug;
  logic [NIRQ-1:0] int_stat, int_en;

  function automatic logic hit(input logic [REG_AW-1:0] a, input int off);
    return a == REG_AW'(off);
  endfunction

  logic wr_ctrl, wr_idle;
  logic [3:0] wcmd;
  assign wr_idle = reg_we_i && !busy;
  assign wr_ctrl = wr_idle && hit(reg_addr_i, OFF_CTRL);
  assign wcmd    = reg_wdata_i[CTRL_CMD_LO +: 4];
  assign launch  = wr_ctrl && reg_wdata_i[CTRL_START] && cmd_legal(wcmd) &&
                   (!reg_wdata_i[CTRL_AONLY] || cmd_is_i2c(wcmd));

  aux_xact_seq #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_seq (
    .clk_i, .rst_ni, .launch_i(launch), .rsp_valid_i,
    .busy_o(busy), .finish_o(finish), .expired_o(expired)
  );

  aux_hpd_mon u_hpd (
    .clk_i, .rst_ni, .hpd_i, .level_o(hpd_lvl), .plug_o(plug), .unplug_o(unplug)
  );

  aux_irq_ctrl #(.NSRC(NIRQ)) u_irq (
    .clk_i, .rst_ni,
    .set_i({unplug, plug, sink_irq_i, finish}),
    .clr_we_i(reg_we_i && hit(reg_addr_i, OFF_INTS)),
    .en_we_i(reg_we_i && hit(reg_addr_i, OFF_INTEN)),
    .wdata_i(reg_wdata_i[NIRQ-1:0]),
    .stat_o(int_stat), .en_o(int_en), .irq_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      len_m1_q <= '0;
      aonly_q  <= 1'b0;
      cmd_q    <= '0;
    end else begin
      if (wr_idle && hit(reg_addr_i, OFF_ADDR)) addr_q <= reg_wdata_i[ADDR_W-1:0];
      if (wr_ctrl) begin
        len_m1_q <= reg_wdata_i[LEN_W-1:0];
        aonly_q  <= reg_wdata_i[CTRL_AONLY];
        cmd_q    <= wcmd;
      end
    end
  end

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tx_q[g] <= '0;
        rx_q[g] <= '0;
      end else begin
        if (wr_idle && hit(reg_addr_i, OFF_TX + g)) tx_q[g] <= reg_wdata_i;
        if (finish && rsp_valid_i) rx_q[g] <= rsp_data_i[32*g +: 32];
      end
    end
  end

  // error bits: [0] timeout, [1] rx, [2] sink-status, [3] missing stop
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      type_q  <= '0;
      count_q <= '0;
      err_q   <= '0;
    end else begin
      logic [3:0] clr, set;
      clr = (reg_we_i && hit(reg_addr_i, OFF_STAT)) ? reg_wdata_i[STAT_ERR_LO +: 4] : 4'b0;
      set = '0;
      if (finish && rsp_valid_i) begin
        type_q  <= rsp_type_i;
        count_q <= rsp_count_i;
        set     = {rsp_err_i, 1'b0};
      end else if (expired) begin
        count_q <= '0;
        set     = 4'b0001;
      end
      err_q <= (err_q & ~clr) | set;
    end
  end

  assign req_valid_o     = busy;
  assign req_cmd_o       = cmd_q;
  assign req_addr_o      = addr_q;
  assign req_addr_only_o = aonly_q;
  assign req_len_o       = aonly_q ? '0 : CNT_W'(len_m1_q) + 1'b1;
  assign req_data_o      = tx_q;

  always_comb begin
    reg_rdata_o = '0;
    if (hit(reg_addr_i, OFF_ADDR)) reg_rdata_o[ADDR_W-1:0] = addr_q;
    if (hit(reg_addr_i, OFF_CTRL)) begin
      reg_rdata_o[LEN_W-1:0]          = len_m1_q;
      reg_rdata_o[CTRL_AONLY]         = aonly_q;
      reg_rdata_o[CTRL_CMD_LO +: 4]   = cmd_q;
      reg_rdata_o[CTRL_START]         = busy;
    end
    if (hit(reg_addr_i, OFF_STAT)) begin
      reg_rdata_o[CNT_W-1:0]          = count_q;
      reg_rdata_o[STAT_ERR_LO +: 4]   = err_q;
      reg_rdata_o[STAT_TYPE_LO +: 4]  = type_q;
      reg_rdata_o[STAT_HPD]           = hpd_lvl;
    end
    if (hit(reg_addr_i, OFF_INTS))  reg_rdata_o[NIRQ-1:0] = int_stat;
    if (hit(reg_addr_i, OFF_INTEN)) reg_rdata_o[NIRQ-1:0] = int_en;
    for (int k = 0; k < NWORDS; k++) begin
      if (hit(reg_addr_i, OFF_TX + k)) reg_rdata_o = tx_q[k];
      if (hit(reg_addr_i, OFF_RX + k)) reg_rdata_o = rx_q[k];
    end
  end

  assert_payload_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && $past(req_valid_o)) |->
      ($stable(req_addr_o) && $stable(req_data_o) && $stable(req_cmd_o) && $stable(req_len_o)));
  assert_done_on_finish_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finish |=> (int_stat[0] && !req_valid_o));
  assert_no_native_aonly_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> !(req_addr_only_o && !req_cmd_o[2]));
  assert_legal_cmd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_valid_o) |-> cmd_legal(req_cmd_o));
endmodule

// File: tb/aux_xact_ctrl_tb.sv
`timescale 1ns/1ps
module aux_xact_ctrl_tb_top;
  localparam int TO = 40;
  localparam int PW = 128;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        req_valid, req_aonly;
  logic [3:0]  req_cmd;
  logic [19:0] req_addr;
  logic [4:0]  req_len;
  logic [PW-1:0] req_data;
  logic        rsp_valid = 1'b0;
  logic [3:0]  rsp_type = '0;
  logic [4:0]  rsp_count = '0;
  logic [2:0]  rsp_err = '0;
  logic [PW-1:0] rsp_data = '0;
  logic        hpd = 1'b0, sink_irq = 1'b0, irq;

  aux_xact_ctrl #(.TIMEOUT_CYC(TO)) dut_i (
    .clk_i(clk), .rst_ni, .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .req_valid_o(req_valid), .req_cmd_o(req_cmd), .req_addr_o(req_addr),
    .req_len_o(req_len), .req_addr_only_o(req_aonly), .req_data_o(req_data),
    .rsp_valid_i(rsp_valid), .rsp_type_i(rsp_type), .rsp_count_i(rsp_count),
    .rsp_err_i(rsp_err), .rsp_data_i(rsp_data),
    .hpd_i(hpd), .sink_irq_i(sink_irq), .irq_o(irq)
  );

  int checks = 0, fails = 0;

  task automatic chk(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic reply(input logic [3:0] t, input logic [4:0] c, input logic [2:0] e,
                       input logic [PW-1:0] d);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_type = t; rsp_count = c; rsp_err = e; rsp_data = d;
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  function automatic logic [31:0] ctrl(input logic [3:0] cmd, input logic [3:0] lm1,
                                       input logic ao, input logic st);
    return {15'b0, st, 4'b0, cmd, 3'b0, ao, lm1};
  endfunction

  typedef struct packed {
    logic [3:0] cmd;
    logic [3:0] lm1;
    logic       ao;
    logic [3:0] rtype;
    logic [4:0] rcnt;
    logic [2:0] rerr;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{4'h1, 4'hF, 1'b0, 4'h0, 5'd16, 3'd0},
    '{4'h5, 4'h3, 1'b0, 4'h4, 5'd0,  3'd0},
    '{4'h0, 4'h0, 1'b0, 4'h2, 5'd0,  3'd1},
    '{4'hD, 4'h7, 1'b0, 4'h0, 5'd5,  3'd0},
    '{4'h6, 4'h0, 1'b1, 4'h8, 5'd0,  3'd4},
    '{4'hE, 4'h1, 1'b0, 4'h1, 5'd0,  3'd2}
  };

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] r;
    logic [PW-1:0] txd, rxd;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), r);
      chk($sformatf("R1 reg%0d", a), r, 0);
    end
    chk("R1 req_valid", req_valid, 0);
    chk("R1 irq", irq, 0);

    // vector table: R2 R3 R6
    for (int v = 0; v < 6; v++) begin
      wr(4'd0, 32'h0_1000 + v);
      for (int w = 0; w < 4; w++) begin
        txd[32*w +: 32] = 32'hA0B0_C000 + 32'(v*16 + w);
        wr(4'(8 + w), txd[32*w +: 32]);
        rxd[32*w +: 32] = 32'h1122_3344 ^ 32'(v << 8) ^ 32'(w);
      end
      wr(4'd1, ctrl(VEC[v].cmd, VEC[v].lm1, VEC[v].ao, 1'b1));
      chk("R2 req_valid", req_valid, 1);
      chk("R2 req_cmd", req_cmd, VEC[v].cmd);
      chk("R2 req_addr", req_addr, 20'h0_1000 + 20'(v));
      chk("R2 req_len", req_len, VEC[v].ao ? 5'd0 : 5'(VEC[v].lm1) + 5'd1);
      chk("R2 req_aonly", req_aonly, VEC[v].ao);
      chk("R3 req_data", req_data, txd);
      rd(4'd1, r);
      chk("R2 start bit busy", r[16], 1);
      reply(VEC[v].rtype, VEC[v].rcnt, VEC[v].rerr, rxd);
      rd(4'd2, r);
      chk("R6 status", r, {12'b0, VEC[v].rtype, 4'b0, VEC[v].rerr, 1'b0, 3'b0, VEC[v].rcnt});
      rd(4'd1, r);
      chk("R6 start cleared", r[16], 0);
      rd(4'd3, r);
      chk("R6 done int", r[0], 1);
      rd(4'(12 + (v % 4)), r);
      chk("R6 rx word", r, rxd[32*(v%4) +: 32]);
      wr(4'd2, 32'hF00);
      wr(4'd3, 32'h1);
      rd(4'd2, r);
      chk("R8 full clear", r[11:8], 0);
    end

    // R3 byte order
    wr(4'd1, ctrl(4'h1, 4'hF, 1'b0, 1'b1));
    for (int k = 0; k < 16; k++) rxd[8*k +: 8] = 8'(k + 1);
    reply(4'h0, 5'd16, 3'd0, rxd);
    rd(4'd12, r); chk("R3 rx word0", r, 32'h0403_0201);
    rd(4'd15, r); chk("R3 rx word3", r, 32'h100F_0E0D);
    wr(4'd3, 32'hF);

    // R4 native address-only rejected
    wr(4'd1, ctrl(4'h1, 4'h0, 1'b1, 1'b1));
    chk("R4 no launch", req_valid, 0);
    rd(4'd1, r); chk("R4 start bit", r[16], 0);
    // R4 i2c address-only accepted with zero length
    wr(4'd1, ctrl(4'h4, 4'h3, 1'b1, 1'b1));
    chk("R4 i2c aonly launch", req_valid, 1);
    chk("R4 i2c aonly len", req_len, 0);
    reply(4'h0, 5'd0, 3'd0, '0);

    // R5 undefined command
    wr(4'd1, ctrl(4'h3, 4'h1, 1'b0, 1'b1));
    chk("R5 no launch code3", req_valid, 0);
    wr(4'd1, ctrl(4'h9, 4'h1, 1'b0, 1'b1));
    chk("R5 no launch code9", req_valid, 0);

    // R7 timeout and R9 writes ignored while busy
    wr(4'd2, 32'hF00);
    wr(4'd3, 32'hF);
    wr(4'd0, 32'h0_0ABC);
    wr(4'd1, ctrl(4'h1, 4'h1, 1'b0, 1'b1));
    // two writes consume 4 busy edges
    wr(4'd0, 32'h0_0DEF);
    wr(4'd8, 32'hDEAD_BEEF);
    chk("R9 req_addr held", req_addr, 20'h0_0ABC);
    rd(4'd0, r); chk("R9 addr reg", r, 32'h0_0ABC);
    rd(4'd8, r); chk("R9 tx reg", r, 32'hA0B0_C050);
    repeat (TO - 1 - 4) @(negedge clk);
    chk("R7 busy before limit", req_valid, 1);
    @(negedge clk);
    chk("R7 ended at limit", req_valid, 0);
    rd(4'd2, r);
    chk("R7 timeout flag", r[8], 1);
    chk("R7 count zero", r[4:0], 0);
    rd(4'd3, r); chk("R7 done int", r[0], 1);

    // R8 partial clear
    wr(4'd1, ctrl(4'h1, 4'h0, 1'b0, 1'b1));
    reply(4'h0, 5'd1, 3'd1, '0);
    rd(4'd2, r); chk("R8 sticky", r[11:8], 4'b0011);
    wr(4'd2, 32'h200);
    rd(4'd2, r); chk("R8 partial", r[11:8], 4'b0001);

    // R13 reply while idle
    rd(4'd2, r);
    reply(4'hF, 5'd9, 3'd7, {PW{1'b1}});
    begin
      logic [31:0] r2;
      rd(4'd2, r2); chk("R13 status kept", r2, r);
      rd(4'd13, r2); chk("R13 rx kept", r2, 32'h0);
    end

    // R10 W1C and enable
    wr(4'd3, 32'hF);
    wr(4'd1, ctrl(4'h0, 4'h0, 1'b0, 1'b1));
    reply(4'h0, 5'd0, 3'd0, '0);
    chk("R10 irq masked", irq, 0);
    wr(4'd4, 32'h1);
    chk("R10 irq enabled", irq, 1);
    wr(4'd3, 32'h2);
    rd(4'd3, r); chk("R10 other bit kept", r[3:0], 4'h1);
    wr(4'd3, 32'h1);
    chk("R10 irq cleared", irq, 0);

    // R12 sink irq
    @(negedge clk); sink_irq = 1'b1;
    @(negedge clk); sink_irq = 1'b0;
    rd(4'd3, r); chk("R12 sink int", r[1], 1);
    wr(4'd3, 32'h2);

    // R11 hot plug
    @(negedge clk); hpd = 1'b1;
    @(negedge clk); rd(4'd2, r); chk("R11 level not yet", r[28], 0);
    @(negedge clk); rd(4'd2, r); chk("R11 level synced", r[28], 1);
    @(negedge clk); rd(4'd3, r); chk("R11 plug int", r[3:2], 2'b01);
    wr(4'd3, 32'hF);
    @(negedge clk); hpd = 1'b0;
    repeat (4) @(negedge clk);
    rd(4'd3, r); chk("R11 unplug int", r[3:2], 2'b10);
    rd(4'd2, r); chk("R11 level low", r[28], 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule